// File: doc/BRIEF.md
# Address-Masked GPIO Peripheral

This block is an eight-line general-purpose I/O controller on a simple APB-style register bus. Its data register has no single address. Address bits [9:2] act as a per-pin select mask, so one bus access can read or change any chosen subset of pins. Software therefore never needs a read-modify-write to flip a single pin. Pin numbers above seven belong to other instances: the instance is the pin number divided by 8, and the bit within it is the pin number modulo 8.

Each pin has a direction bit and a choice between software control and a hardware function. It also has its own interrupt detector. The detector is set per pin to level or edge sense, to either-edge triggering, and to a polarity. Raw and enabled interrupt status can be read back, edge events are cleared by writing ones, and all enabled events are ORed onto a single interrupt line. Pad inputs pass through a two-flop synchronizer before any read or detection sees them.

Top module: `gpio_masked`

## Requirements
- R1: After reset, every register reads 0, pin_oe, pin_out and irq are 0, and a data read of pins held low returns 0.
- R2: The direction register sits at offset 0x400. Bit n = 1 drives pin_oe[n] high (output), and 0 makes the pin an input.
- R3: A data read at any aligned offset below 0x400 uses address bit n+2 as the select for pin n. A selected bit returns the output register bit for an output pin and the synchronized pad value for an input pin. An unselected bit returns 0.
- R4: A data write below 0x400 updates only the output-register bits whose select bit is 1. All other bits keep their value.
- R5: The mode register sits at offset 0x420. Bit n = 1 routes hw_dout[n] to pin_out[n], and 0 routes the output register bit. hw_din always carries the synchronized pad values.
- R6: Edge sense is selected by a 0 in the sense register (0x404). A 1 in the both-edges register (0x408) triggers on either edge. Otherwise the event register (0x40C) selects rising (1) or falling (0). A detected edge sets its raw status bit, and the bit stays set.
- R7: Writing 1 to bit n of the clear register (0x41C) clears edge status bit n. Writing 0 leaves it unchanged.
- R8: Level sense is selected by a 1 in the sense register. The raw bit is then 1 while the pad equals the event bit (1 = high, 0 = low), and writes to the clear register do not change it.
- R9: Raw status reads at 0x414. Masked status at 0x418 equals raw AND the enable register (0x410). irq is the OR of the masked bits.
- R10: Reads of unused or write-only offsets (0x41C, 0x424 and above) return 0. Writes to them, and to the status offsets 0x414 and 0x418, change nothing.
- R11: A pad change reaches data reads after two clock edges. It is not visible after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid while selected for read |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| hw_dout | input | 8 | Output values from the hardware function |
| hw_din | output | 8 | Synchronized pad values for the hardware function |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check four things on every cycle. A data write leaves unselected output bits untouched, and a data read returns zero on unselected bits. An edge flag never drops without a clear and only rises after the synchronized input has changed. irq cannot rise while no enable bit is set. Only the bench's scenarios can show the rest. The full arithmetic of masked writes and reads over all 256 masks, the per-pin mixing of rising, falling and either-edge sense, level polarity and its immunity to clears, the two-edge input latency, and the hardware-function routing all depend on sequences that no single-cycle property captures.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // word index of each control register inside the control page
  localparam int unsigned IDX_DIR   = 0;
  localparam int unsigned IDX_SENSE = 1;
  localparam int unsigned IDX_BOTH  = 2;
  localparam int unsigned IDX_EVT   = 3;
  localparam int unsigned IDX_IEN   = 4;
  localparam int unsigned IDX_RAW   = 5;
  localparam int unsigned IDX_MSK   = 6;
  localparam int unsigned IDX_CLR   = 7;
  localparam int unsigned IDX_MODE  = 8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int W = 8
) (
  input  logic [W-1:0] mode,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] dout,
  input  logic [W-1:0] hw_dout,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pin_out[i] = mode[i] ? hw_dout[i] : dout[i];
    assign pin_oe[i]  = dir[i];
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] both,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] raw
);
  logic [W-1:0] prev_q;
  logic [W-1:0] flag_q;
  logic [W-1:0] flag_n;
  logic [W-1:0] rise;
  logic [W-1:0] fall;
  logic [W-1:0] hit;
  logic [W-1:0] lvl_hit;

  always_comb begin
    rise    = lvl & ~prev_q;
    fall    = ~lvl & prev_q;
    hit     = ~sense & ((both & (rise | fall)) |
                        (~both & evt & rise) |
                        (~both & ~evt & fall));
    lvl_hit = sense & ~(lvl ^ evt);
    flag_n  = (flag_q & ~clr) | hit;   // a new edge wins over a clear
    raw     = lvl_hit | (~sense & flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= lvl;
      flag_q <= flag_n;
    end
  end

  // R7: a flag only drops when its clear bit was written
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(flag_q) & ~$past(clr)) & ~flag_q) == '0));

  // R6: a flag only rises after the synchronized input changed
  assert_flag_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q)) != '0) |-> ($past(lvl) != $past(prev_q)));
endmodule

// File: rtl/gpio_masked.sv
module gpio_masked #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [NPINS-1:0]  pwdata,
  output logic [NPINS-1:0]  prdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [NPINS-1:0]  hw_dout,
  output logic [NPINS-1:0]  hw_din,
  output logic              irq
);
  import gpio_pkg::*;

  localparam int DATA_AW = NPINS + 2;         // data window spans 1<<DATA_AW bytes
  localparam int PAGE_W  = ADDR_W - DATA_AW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_n;
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) rst_q <= 2'b00;
    else          rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n = rst_q[1];

  // address decode
  logic             aligned, in_data, in_ctrl, wr_en, rd_en;
  logic [NPINS-1:0] mask;
  logic [NPINS-1:0] cidx;
  logic sel_dir, sel_sense, sel_both, sel_evt, sel_ien, sel_clr, sel_mode;
  logic sel_raw, sel_msk;

  always_comb begin
    aligned   = (paddr[1:0] == 2'b00);
    in_data   = aligned && (paddr[ADDR_W-1:DATA_AW] == '0);
    in_ctrl   = aligned && (paddr[ADDR_W-1:DATA_AW] == PAGE_W'(1));
    mask      = paddr[DATA_AW-1:2];
    cidx      = paddr[DATA_AW-1:2];
    wr_en     = psel && penable && pwrite;
    rd_en     = psel && !pwrite;
    sel_dir   = in_ctrl && (cidx == NPINS'(IDX_DIR));
    sel_sense = in_ctrl && (cidx == NPINS'(IDX_SENSE));
    sel_both  = in_ctrl && (cidx == NPINS'(IDX_BOTH));
    sel_evt   = in_ctrl && (cidx == NPINS'(IDX_EVT));
    sel_ien   = in_ctrl && (cidx == NPINS'(IDX_IEN));
    sel_raw   = in_ctrl && (cidx == NPINS'(IDX_RAW));
    sel_msk   = in_ctrl && (cidx == NPINS'(IDX_MSK));
    sel_clr   = in_ctrl && (cidx == NPINS'(IDX_CLR));
    sel_mode  = in_ctrl && (cidx == NPINS'(IDX_MODE));
  end

  // configuration registers
  logic [NPINS-1:0] dir_q, sense_q, both_q, evt_q, ien_q, mode_q, dout_q;
  logic [NPINS-1:0] dir_n, sense_n, both_n, evt_n, ien_n, mode_n, dout_n;
  logic [NPINS-1:0] clr;

  always_comb begin
    dir_n   = dir_q;
    sense_n = sense_q;
    both_n  = both_q;
    evt_n   = evt_q;
    ien_n   = ien_q;
    mode_n  = mode_q;
    dout_n  = dout_q;
    clr     = '0;
    if (wr_en) begin
      if (in_data)   dout_n  = (dout_q & ~mask) | (pwdata & mask);
      if (sel_dir)   dir_n   = pwdata;
      if (sel_sense) sense_n = pwdata;
      if (sel_both)  both_n  = pwdata;
      if (sel_evt)   evt_n   = pwdata;
      if (sel_ien)   ien_n   = pwdata;
      if (sel_mode)  mode_n  = pwdata;
      if (sel_clr)   clr     = pwdata;
    end
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      evt_q   <= '0;
      ien_q   <= '0;
      mode_q  <= '0;
      dout_q  <= '0;
    end else if (wr_en) begin
      dir_q   <= dir_n;
      sense_q <= sense_n;
      both_q  <= both_n;
      evt_q   <= evt_n;
      ien_q   <= ien_n;
      mode_q  <= mode_n;
      dout_q  <= dout_n;
    end
  end

  // pad input path, detection and pin routing
  logic [NPINS-1:0] pad_s;
  logic [NPINS-1:0] raw;
  logic [NPINS-1:0] msk;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(pclk), .rst_n(rst_n), .d(pin_in), .q(pad_s)
  );

  gpio_irq #(.W(NPINS)) u_irq (
    .clk(pclk), .rst_n(rst_n), .lvl(pad_s), .sense(sense_q),
    .both(both_q), .evt(evt_q), .clr(clr), .raw(raw)
  );

  gpio_pinmux #(.W(NPINS)) u_mux (
    .mode(mode_q), .dir(dir_q), .dout(dout_q), .hw_dout(hw_dout),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign msk    = raw & ien_q;
  assign irq    = |msk;
  assign hw_din = pad_s;

  // read path
  logic [NPINS-1:0] view;
  always_comb begin
    view   = (dir_q & dout_q) | (~dir_q & pad_s);
    prdata = '0;
    if (rd_en) begin
      if (in_data)        prdata = view & mask;
      else if (sel_dir)   prdata = dir_q;
      else if (sel_sense) prdata = sense_q;
      else if (sel_both)  prdata = both_q;
      else if (sel_evt)   prdata = evt_q;
      else if (sel_ien)   prdata = ien_q;
      else if (sel_raw)   prdata = raw;
      else if (sel_msk)   prdata = msk;
      else if (sel_mode)  prdata = mode_q;
    end
  end

  // R4: a data write leaves unselected output bits as they were
  assert_write_keeps_unmasked_R4: assert property (@(posedge pclk) disable iff (!rst_n)
    (wr_en && in_data) |=> ((dout_q & ~$past(mask)) == ($past(dout_q) & ~$past(mask))));

  // R3: unselected bits of a data read are zero
  assert_read_unmasked_zero_R3: assert property (@(posedge pclk) disable iff (!rst_n)
    (rd_en && in_data) |-> ((prdata & ~mask) == '0));

  // R9: no interrupt without an enable bit
  assert_irq_needs_enable_R9: assert property (@(posedge pclk) disable iff (!rst_n)
    irq |-> (ien_q != '0));

  // R10: reads outside the data window and outside the control page are zero
  assert_outside_reads_zero_R10: assert property (@(posedge pclk) disable iff (!rst_n)
    (rd_en && !in_data && !in_ctrl) |-> (prdata == '0));
endmodule

// File: tb/sim_gpio_masked.sv
`timescale 1ns/1ps
module sim_gpio_masked;
  logic        clk = 1'b0;
  logic        presetn;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [7:0]  pwdata, prdata, pin_in, pin_out, pin_oe, hw_dout, hw_din;
  logic        irq;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  gpio_masked u0 (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .hw_dout(hw_dout), .hw_din(hw_din), .irq(irq)
  );

  localparam logic [11:0] A_DIR = 12'h400, A_SENSE = 12'h404, A_BOTH = 12'h408,
    A_EVT = 12'h40C, A_IEN = 12'h410, A_RAW = 12'h414, A_MSK = 12'h418,
    A_CLR = 12'h41C, A_MODE = 12'h420, A_ALL = 12'h3FC;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b1;
    #2 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [11:0] maddr(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, e, p;
    presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; pin_in = '0; hw_dout = '0;
    repeat (3) @(negedge clk);
    presetn = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd(A_DIR, v);   chk("R1 dir", v, 8'h00);
    rd(A_SENSE, v); chk("R1 sense", v, 8'h00);
    rd(A_BOTH, v);  chk("R1 both", v, 8'h00);
    rd(A_EVT, v);   chk("R1 evt", v, 8'h00);
    rd(A_IEN, v);   chk("R1 ien", v, 8'h00);
    rd(A_RAW, v);   chk("R1 raw", v, 8'h00);
    rd(A_MODE, v);  chk("R1 mode", v, 8'h00);
    rd(A_ALL, v);   chk("R1 data", v, 8'h00);

    // R2: direction drives output enables
    wr(A_DIR, 8'hFF);
    chk("R2 oe all", pin_oe, 8'hFF);

    // R4 and R3: every mask, all outputs
    e = 8'h00;
    for (int m = 0; m < 256; m++) begin
      logic [7:0] d, r;
      d = 8'((m * 37 + 11) & 255);
      r = 8'((m * 5 + 3) & 255);
      wr(maddr(8'(m)), d);
      e = (e & ~8'(m)) | (d & 8'(m));
      chk("R4 masked write", pin_out, e);
      rd(maddr(r), v);
      chk("R3 masked read output", v, e & r);
    end

    // R11: two-edge input latency
    wr(A_DIR, 8'h00);
    chk("R2 oe none", pin_oe, 8'h00);
    @(negedge clk);
    pin_in = 8'hAA;
    rd(A_ALL, v); chk("R11 after one edge", v, 8'h00);
    rd(A_ALL, v); chk("R11 after two edges", v, 8'hAA);

    // R3 and R5: every input pattern
    for (int k = 0; k < 256; k++) begin
      logic [7:0] r;
      pin_in = 8'(k);
      settle();
      r = 8'(k) ^ 8'h5A;
      rd(A_ALL, v);    chk("R3 input read", v, 8'(k));
      rd(maddr(r), v); chk("R3 input masked", v, 8'(k) & r);
      chk("R5 hw_din", hw_din, 8'(k));
    end

    // R5: hardware routing, mixed direction read back
    wr(A_DIR, 8'hFF);
    wr(A_ALL, 8'h3C);
    hw_dout = 8'hA5;
    wr(A_MODE, 8'hF0);
    chk("R5 mode mix", pin_out, 8'hAC);
    wr(A_MODE, 8'h00);
    chk("R5 software back", pin_out, 8'h3C);
    wr(A_DIR, 8'h0F);
    p = 8'h96; pin_in = p; settle();
    rd(A_ALL, v); chk("R3 mixed dir", v, (8'h3C & 8'h0F) | (p & 8'hF0));
    wr(A_DIR, 8'h00);

    // R6/R7/R9: per-pin edge modes
    pin_in = 8'h00; settle();
    wr(A_BOTH, 8'h0C);
    wr(A_EVT, 8'hF0);
    wr(A_CLR, 8'hFF);
    rd(A_RAW, v); chk("R7 cleared", v, 8'h00);
    pin_in = 8'hFF; settle();
    rd(A_RAW, v); chk("R6 rising", v, 8'hFC);
    settle();
    rd(A_RAW, v); chk("R6 sticky", v, 8'hFC);
    wr(A_CLR, 8'h00);
    rd(A_RAW, v); chk("R7 zero clear", v, 8'hFC);
    wr(A_CLR, 8'hFF);
    rd(A_RAW, v); chk("R7 clear all", v, 8'h00);
    pin_in = 8'h00; settle();
    rd(A_RAW, v); chk("R6 falling", v, 8'h0F);
    wr(A_CLR, 8'h05);
    rd(A_RAW, v); chk("R7 partial clear", v, 8'h0A);
    chk("R9 irq off", {7'b0, irq}, 8'h00);
    wr(A_IEN, 8'h02);
    rd(A_MSK, v); chk("R9 masked", v, 8'h02);
    chk("R9 irq on", {7'b0, irq}, 8'h01);
    wr(A_IEN, 8'h01);
    rd(A_MSK, v); chk("R9 masked off", v, 8'h00);
    chk("R9 irq off again", {7'b0, irq}, 8'h00);
    wr(A_CLR, 8'hFF);

    // R8: level sense
    wr(A_EVT, 8'h33);
    wr(A_SENSE, 8'hFF);
    pin_in = 8'h0F; settle();
    rd(A_RAW, v); chk("R8 level", v, 8'hC3);
    wr(A_CLR, 8'hFF);
    rd(A_RAW, v); chk("R8 clear ignored", v, 8'hC3);
    pin_in = 8'hF0; settle();
    rd(A_RAW, v); chk("R8 level follows", v, 8'h3C);
    wr(A_IEN, 8'hFF);
    rd(A_MSK, v); chk("R9 level masked", v, 8'h3C);
    chk("R9 level irq", {7'b0, irq}, 8'h01);

    // R10: unused and status offsets
    wr(A_RAW, 8'h00);
    wr(A_MSK, 8'h00);
    rd(A_RAW, v); chk("R10 raw unchanged", v, 8'h3C);
    wr(12'h424, 8'hFF);
    wr(12'h800, 8'hFF);
    wr(12'hFFC, 8'hFF);
    rd(12'h424, v); chk("R10 unused 424", v, 8'h00);
    rd(12'h800, v); chk("R10 unused 800", v, 8'h00);
    rd(12'hFFC, v); chk("R10 unused FFC", v, 8'h00);
    rd(A_CLR, v);   chk("R10 clear reads zero", v, 8'h00);
    rd(A_DIR, v);   chk("R10 dir intact", v, 8'h00);
    rd(A_MODE, v);  chk("R10 mode intact", v, 8'h00);
    rd(A_IEN, v);   chk("R10 ien intact", v, 8'hFF);
    chk("R10 pins intact", pin_out, 8'h3C);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule